// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 42-bit virtual address into a 32-bit physical address. It walks a fixed tree of page tables that sits in memory. The address holds three 10-bit table indices above a 12-bit page offset. Every table is one 4 KB page of 1024 four-byte entries. The walk starts at a root base held by a register outside the block.

The walker reads one entry per level through a plain request/acknowledge memory port, and only one access is outstanding at any time. An entry whose present bit is clear stops the walk and raises a page fault, which reports the level that faulted. A walk that reaches the leaf returns the leaf frame joined with the page offset. When the access needs it, the walker first writes the leaf back with its referenced bit set, and with its modified bit set as well for a write.

Entry layout: bit 0 means present, bit 1 means referenced, bit 2 means modified, and bits 31:12 hold the frame number. Bits 11:3 are carried through unchanged.

Top module: `pgwalk_top`

## Requirements
- R1: A request is taken only while the walker is idle. `busy` goes high in the cycle after the request is taken and stays high until the response. A `req_valid` pulse that arrives while `busy` is high is ignored and produces no extra response.
- R2: The first read goes to byte address `root_base + va[41:32]*4`. Each walk reads the levels in order 1, 2, 3, with one read per level.
- R3: The table base for levels 2 and 3 is bits 31:12 of the entry fetched one level above, shifted left by 12. The read address at that level is this base plus its index field (`va[31:22]` for level 2, `va[21:12]` for level 3) times 4.
- R4: `mem_req` is a one-cycle pulse. No new request is issued until `mem_ack` has answered the previous one.
- R5: An entry with bit 0 clear at level k (1, 2 or 3) ends the walk. The response then has `rsp_fault`=1, `rsp_level`=k and `rsp_va` equal to the request address. No further read and no write follows.
- R6: A walk that succeeds responds with `rsp_fault`=0, `rsp_level`=0, `rsp_va` equal to the request address, and `rsp_pa` = {leaf bits 31:12, va[11:0]}.
- R7: On a read access whose leaf has bit 1 clear, the walker writes the leaf back to the leaf's own address, with bit 1 set, before it responds.
- R8: On a write access whose leaf has bit 2 clear, the walker writes the leaf back with bits 1 and 2 both set.
- R9: No write-back is issued when a read access finds bit 1 already set, or when a write access finds bits 1 and 2 already set.
- R10: While `rst` is held and in the cycle after it is released, `busy`, `mem_req` and `rsp_valid` are all low.
- R11: A write-back caused by a read access leaves bit 2 as the leaf had it. All other bits are unchanged except bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 42 | Virtual address to translate |
| req_write | input | 1 | 1 for a store access, 0 for a load |
| root_base | input | 32 | Byte address of the top-level table (4 KB aligned) |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access strobe, one cycle |
| mem_we | output | 1 | 1 for a write-back, 0 for an entry read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Leaf entry data for a write-back |
| mem_ack | input | 1 | Memory finished the outstanding access |
| mem_rdata | input | 32 | Entry data, valid with `mem_ack` on a read |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_fault | output | 1 | Page fault |
| rsp_level | output | 2 | Faulting level 1 to 3, or 0 on success |
| rsp_pa | output | 32 | Translated physical address |
| rsp_va | output | 42 | Virtual address of the finished request |

## Verification
The bench builds two separate table trees in a model memory. It translates a set of addresses that picks a different index at each level, including the smallest and largest index values. Successful walks are run against leaves in three states: nothing set, only referenced set, and both referenced and modified set. Each state is tried with loads and with stores, so the three write-back outcomes can be told apart. Not-present entries placed at each of the three levels show whether the fault level is right and whether the walk stops early. A request sent during a walk shows whether the idle-only acceptance holds. The model memory answers after varying delays, which exposes any second access issued before the acknowledge.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int unsigned LEVELS   = 3;
  localparam int unsigned P_BIT    = 0;
  localparam int unsigned R_BIT    = 1;
  localparam int unsigned M_BIT    = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_READ,
    ST_L2_READ,
    ST_L3_READ,
    ST_UPDATE,
    ST_DONE,
    ST_FAULT
  } walk_state_e;
endpackage

// File: rtl/pgwalk_idx_sel.sv
module pgwalk_idx_sel
  import pgwalk_pkg::*;
#(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned LVL_W  = 2,
  parameter int unsigned ENT_SH = 2,
  localparam int unsigned VPN_W = LEVELS * IDX_W
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [PA_W-1:0]  base,
  input  logic [LVL_W-1:0] lvl,
  output logic [PA_W-1:0]  ent_addr
);
  logic [LEVELS-1:0][IDX_W-1:0] idx;
  logic [IDX_W-1:0]             sel;

  // Level 0 takes the most significant index field.
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx[g] = vpn[VPN_W-1-g*IDX_W -: IDX_W];
  end

  always_comb begin
    sel = '0;
    for (int g = 0; g < LEVELS; g++) begin
      if (lvl == LVL_W'(g)) sel = idx[g];
    end
  end

  assign ent_addr = base + (PA_W'(sel) << ENT_SH);
endmodule

// File: rtl/pgwalk_wb_calc.sv
module pgwalk_wb_calc
  import pgwalk_pkg::*;
#(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned FRAME_W = PA_W - OFF_W
) (
  input  logic [PA_W-1:0]    entry,
  input  logic               is_write,
  output logic               present,
  output logic [FRAME_W-1:0] frame,
  output logic               need_wb,
  output logic [PA_W-1:0]    wb_data
);
  logic [PA_W-1:0] set_mask;

  assign present = entry[P_BIT];
  assign frame   = entry[PA_W-1:OFF_W];

  always_comb begin
    set_mask        = '0;
    set_mask[R_BIT] = 1'b1;
    set_mask[M_BIT] = is_write;
  end

  assign wb_data = entry | set_mask;
  assign need_wb = (wb_data != entry);
endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
#(
  parameter int unsigned VA_W  = 42,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned LVL_W = 2,
  localparam int unsigned FRAME_W = PA_W - OFF_W,
  localparam int unsigned VPN_W   = VA_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_va,
  input  logic               req_write,
  input  logic [PA_W-1:0]    root_base,
  input  logic               mem_ack,
  input  logic [PA_W-1:0]    ent_addr,
  input  logic               ent_present,
  input  logic [FRAME_W-1:0] ent_frame,
  input  logic               ent_need_wb,
  input  logic [PA_W-1:0]    ent_wb_data,
  output logic [LVL_W-1:0]   lvl_sel,
  output logic [VPN_W-1:0]   vpn_q,
  output logic [PA_W-1:0]    base_q,
  output logic               wr_q,
  output logic               busy,
  output logic               mem_req,
  output logic               mem_we,
  output logic [PA_W-1:0]    mem_addr,
  output logic [PA_W-1:0]    mem_wdata,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [LVL_W-1:0]   rsp_level,
  output logic [PA_W-1:0]    rsp_pa,
  output logic [VA_W-1:0]    rsp_va
);
  walk_state_e         state;
  logic                issued;
  logic [VA_W-1:0]     va_q;
  logic [FRAME_W-1:0]  leaf_frame;
  logic [LVL_W-1:0]    fault_lvl;
  logic [PA_W-1:0]     wb_data_q;

  assign vpn_q = va_q[VA_W-1:OFF_W];

  always_comb begin
    case (state)
      ST_L2_READ: lvl_sel = LVL_W'(1);
      ST_L3_READ: lvl_sel = LVL_W'(2);
      default:    lvl_sel = LVL_W'(0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      issued     <= 1'b0;
      busy       <= 1'b0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_level  <= '0;
      rsp_pa     <= '0;
      rsp_va     <= '0;
      va_q       <= '0;
      wr_q       <= 1'b0;
      base_q     <= '0;
      leaf_frame <= '0;
      fault_lvl  <= '0;
      wb_data_q  <= '0;
    end else begin
      mem_req   <= 1'b0;
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= req_va;
            wr_q   <= req_write;
            base_q <= root_base;
            busy   <= 1'b1;
            state  <= ST_L1_READ;
          end
        end
        ST_L1_READ, ST_L2_READ, ST_L3_READ: begin
          if (!issued) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= ent_addr;
            issued   <= 1'b1;
          end else if (mem_ack) begin
            issued <= 1'b0;
            if (!ent_present) begin
              fault_lvl <= lvl_sel + LVL_W'(1);
              state     <= ST_FAULT;
            end else if (state != ST_L3_READ) begin
              base_q <= {ent_frame, {OFF_W{1'b0}}};
              state  <= (state == ST_L1_READ) ? ST_L2_READ : ST_L3_READ;
            end else begin
              leaf_frame <= ent_frame;
              wb_data_q  <= ent_wb_data;
              state      <= ent_need_wb ? ST_UPDATE : ST_DONE;
            end
          end
        end
        ST_UPDATE: begin
          if (!issued) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_wdata <= wb_data_q;
            issued    <= 1'b1;
          end else if (mem_ack) begin
            issued <= 1'b0;
            state  <= ST_DONE;
          end
        end
        ST_DONE: begin
          rsp_valid <= 1'b1;
          rsp_fault <= 1'b0;
          rsp_level <= '0;
          rsp_pa    <= {leaf_frame, va_q[OFF_W-1:0]};
          rsp_va    <= va_q;
          busy      <= 1'b0;
          state     <= ST_IDLE;
        end
        ST_FAULT: begin
          rsp_valid <= 1'b1;
          rsp_fault <= 1'b1;
          rsp_level <= fault_lvl;
          rsp_pa    <= '0;
          rsp_va    <= va_q;
          busy      <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R5
  fault_level_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_level != '0 && rsp_level <= LVL_W'(3)));

  // R6
  pa_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (rsp_pa[OFF_W-1:0] == rsp_va[OFF_W-1:0]));

  // R7
  wb_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[R_BIT]);

  // R8
  wb_mod_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && wr_q) |-> mem_wdata[M_BIT]);
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PA_W  = 32,
  localparam int unsigned VA_W    = LEVELS * IDX_W + OFF_W,
  localparam int unsigned VPN_W   = VA_W - OFF_W,
  localparam int unsigned FRAME_W = PA_W - OFF_W,
  localparam int unsigned LVL_W   = $clog2(LEVELS + 1),
  localparam int unsigned ENT_SH  = $clog2(PA_W / 8)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  input  logic [PA_W-1:0]  root_base,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PA_W-1:0]  mem_wdata,
  input  logic             mem_ack,
  input  logic [PA_W-1:0]  mem_rdata,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [LVL_W-1:0] rsp_level,
  output logic [PA_W-1:0]  rsp_pa,
  output logic [VA_W-1:0]  rsp_va
);
  logic [LVL_W-1:0]   lvl_sel;
  logic [VPN_W-1:0]   vpn_q;
  logic [PA_W-1:0]    base_q;
  logic [PA_W-1:0]    ent_addr;
  logic               wr_q;
  logic               ent_present;
  logic [FRAME_W-1:0] ent_frame;
  logic               ent_need_wb;
  logic [PA_W-1:0]    ent_wb_data;

  pgwalk_idx_sel #(
    .IDX_W(IDX_W), .PA_W(PA_W), .LVL_W(LVL_W), .ENT_SH(ENT_SH)
  ) u_idx (
    .vpn(vpn_q), .base(base_q), .lvl(lvl_sel), .ent_addr(ent_addr)
  );

  pgwalk_wb_calc #(.PA_W(PA_W), .OFF_W(OFF_W)) u_wb (
    .entry(mem_rdata), .is_write(wr_q), .present(ent_present),
    .frame(ent_frame), .need_wb(ent_need_wb), .wb_data(ent_wb_data)
  );

  pgwalk_ctrl #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .LVL_W(LVL_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .req_write(req_write), .root_base(root_base), .mem_ack(mem_ack),
    .ent_addr(ent_addr), .ent_present(ent_present), .ent_frame(ent_frame),
    .ent_need_wb(ent_need_wb), .ent_wb_data(ent_wb_data),
    .lvl_sel(lvl_sel), .vpn_q(vpn_q), .base_q(base_q), .wr_q(wr_q),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_level(rsp_level), .rsp_pa(rsp_pa), .rsp_va(rsp_va)
  );
endmodule

// File: tb/sim_pgwalk_top.sv
`timescale 1ns/1ps
module sim_pgwalk_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [41:0] req_va;
  logic [31:0] root_base;
  logic        busy, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        rsp_valid, rsp_fault;
  logic [1:0]  rsp_level;
  logic [31:0] rsp_pa;
  logic [41:0] rsp_va;

  always #2 clk = ~clk;

  pgwalk_top u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .req_write(req_write), .root_base(root_base), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_level(rsp_level),
    .rsp_pa(rsp_pa), .rsp_va(rsp_va)
  );

  int n_chk = 0;
  int n_fail = 0;
  int resp_cnt = 0;

  task automatic chk(bit ok, string r, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  // Model memory
  logic [31:0] mem [logic [31:0]];
  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  logic [31:0] rd_log [$];
  int          wr_cnt;
  logic [31:0] wr_a, wr_d;
  bit          pend = 0;
  int          pend_cnt, req_seq = 0;
  logic [31:0] p_addr, p_wd;
  bit          p_we;

  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_ack = 1'b1;
        pend = 0;
        if (p_we) begin
          mem[p_addr] = p_wd;
          wr_cnt++;
          wr_a = p_addr;
          wr_d = p_wd;
        end else begin
          mem_rdata = rd(p_addr);
        end
      end else begin
        pend_cnt--;
      end
    end
    if (!rst && mem_req) begin
      chk(!pend, "R4", "request while one outstanding", 64'(pend), 64'h0);
      pend = 1;
      p_addr = mem_addr;
      p_we = mem_we;
      p_wd = mem_wdata;
      pend_cnt = req_seq % 3;
      req_seq++;
      if (!mem_we) rd_log.push_back(mem_addr);
    end
  end

  typedef struct packed {
    bit              fault;
    logic [1:0]      lvl;
    logic [31:0]     pa;
    logic [41:0]     va;
    bit              wr;
    logic [1:0]      nrd;
    logic [2:0][31:0] a;
    bit              wb;
    logic [31:0]     wbaddr;
    logic [31:0]     wbdata;
  } exp_t;

  exp_t sb [$];

  function automatic exp_t predict(logic [41:0] va, bit wr, logic [31:0] root);
    exp_t e;
    logic [31:0] base, addr, ent;
    e = '0;
    e.va = va;
    e.wr = wr;
    base = root;
    for (int l = 0; l < 3; l++) begin
      addr = base + {20'h0, va[41-10*l -: 10], 2'b00};
      e.a[l] = addr;
      e.nrd = e.nrd + 2'd1;
      ent = rd(addr);
      if (!ent[0]) begin
        e.fault = 1;
        e.lvl = 2'(l + 1);
        return e;
      end
      if (l < 2) base = {ent[31:12], 12'h0};
      else begin
        e.pa = {ent[31:12], va[11:0]};
        e.wb = !ent[1] || (wr && !ent[2]);
        e.wbaddr = addr;
        e.wbdata = ent | 32'h2 | (wr ? 32'h4 : 32'h0);
      end
    end
    return e;
  endfunction

  // Monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) begin
        chk(0, "R1", "response with no accepted request", 64'(rsp_va), 64'h0);
      end else begin
        exp_t e;
        string wtag;
        e = sb.pop_front();
        chk(rsp_fault == e.fault, e.fault ? "R5" : "R6", "fault flag", 64'(rsp_fault), 64'(e.fault));
        chk(rsp_level == e.lvl, e.fault ? "R5" : "R6", "level", 64'(rsp_level), 64'(e.lvl));
        chk(rsp_va == e.va, "R6", "response va", 64'(rsp_va), 64'(e.va));
        if (!e.fault) chk(rsp_pa == e.pa, "R6", "physical address", 64'(rsp_pa), 64'(e.pa));
        chk(rd_log.size() == int'(e.nrd), e.fault ? "R5" : "R2", "read count", 64'(rd_log.size()), 64'(e.nrd));
        for (int i = 0; i < int'(e.nrd) && i < rd_log.size(); i++)
          chk(rd_log[i] == e.a[i], (i == 0) ? "R2" : "R3", "read address", 64'(rd_log[i]), 64'(e.a[i]));
        if (e.fault) wtag = "R5";
        else if (!e.wb) wtag = "R9";
        else if (e.wr) wtag = "R8";
        else wtag = "R7";
        chk(wr_cnt == (e.wb ? 1 : 0), wtag, "write-back count", 64'(wr_cnt), 64'(e.wb));
        if (e.wb && wr_cnt == 1) begin
          chk(wr_a == e.wbaddr, wtag, "write-back address", 64'(wr_a), 64'(e.wbaddr));
          chk(wr_d == e.wbdata, wtag, "write-back data", 64'(wr_d), 64'(e.wbdata));
          if (!e.wr) chk(wr_d[2] == e.wbdata[2], "R11", "modified bit kept on load", 64'(wr_d[2]), 64'(e.wbdata[2]));
        end
      end
      resp_cnt++;
    end
  end

  task automatic walk(logic [41:0] va, bit wr, bit poke);
    int target;
    rd_log.delete();
    wr_cnt = 0;
    sb.push_back(predict(va, wr, root_base));
    target = resp_cnt + 1;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R1", "busy after accept", 64'(busy), 64'h1);
    if (poke) begin
      req_valid = 1'b1; req_va = ~va; req_write = !wr;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (resp_cnt < target) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [41:0] mkva(int i1, int i2, int i3, int off);
    return {10'(i1), 10'(i2), 10'(i3), 12'(off)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_va = '0; req_write = 1'b0;
    mem_ack = 1'b0; mem_rdata = '0;
    root_base = 32'h0001_0000;
    mem[32'h0001_0004] = 32'h0002_0001;
    mem[32'h0002_0008] = 32'h0003_0001;
    mem[32'h0003_000C] = 32'h1234_5001;
    mem[32'h0003_0010] = 32'h0ABC_D003;
    mem[32'h0003_0014] = 32'h0777_7007;
    mem[32'h0003_0018] = 32'h0555_5000;
    mem[32'h0040_0FFC] = 32'h0060_0001;
    mem[32'h0060_0000] = 32'h0061_0001;
    mem[32'h0061_0800] = 32'h0FFF_F001;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !rsp_valid, "R10", "outputs in reset", {busy, mem_req, rsp_valid}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_req && !rsp_valid, "R10", "outputs after reset", {busy, mem_req, rsp_valid}, 64'h0);

    walk(mkva(1, 2, 3, 'hABC), 1'b0, 1'b1);
    walk(mkva(1, 2, 3, 'h001), 1'b0, 1'b0);
    walk(mkva(1, 2, 3, 'hFFF), 1'b1, 1'b0);
    walk(mkva(1, 2, 3, 'h123), 1'b1, 1'b1);
    walk(mkva(1, 2, 4, 'h123), 1'b0, 1'b0);
    walk(mkva(1, 2, 4, 'h456), 1'b1, 1'b0);
    walk(mkva(1, 2, 5, 'h789), 1'b1, 1'b0);
    walk(mkva(5, 0, 0, 'h010), 1'b0, 1'b1);
    walk(mkva(1, 7, 0, 'h020), 1'b1, 1'b0);
    walk(mkva(1, 2, 6, 'h030), 1'b1, 1'b0);
    root_base = 32'h0040_0000;
    walk(mkva(1023, 0, 512, 'hFFF), 1'b1, 1'b0);
    walk(mkva(1023, 0, 512, 'h000), 1'b0, 1'b0);

    repeat (20) @(negedge clk);
    chk(sb.size() == 0, "R1", "responses outstanding at end", 64'(sb.size()), 64'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule